// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block drives the reprogramming of a single PLL without software stepping through it. A one-cycle start command carries three divider values: the reference divider (NR), the feedback multiplier (NF) and the output divider (NO). The block first checks these values against the legal VCO and output frequency windows, which are computed in kHz from a 24 MHz reference. If the request is illegal, the block flags an error and leaves every register untouched.

A legal request runs through a fixed order of steps:

1. The PLL is moved to slow (bypass) mode.
2. PLL reset is asserted.
3. The encoded divider and bandwidth fields are written.
4. Reset is held for a time derived from the system clock frequency.
5. Reset is released.
6. The block waits for the lock input.
7. The mode field returns to normal and `done` pulses.

If lock does not arrive within a bounded number of cycles, the block raises `err` and leaves the PLL in slow mode.

The outputs form a register-style image of four 32-bit control words and a 2-bit mode field, which neighbouring logic applies to the analog PLL. The analog PLL itself is outside the block; only its lock status comes in.

Top module: `pll_prog_seq`

## Requirements
- R1: After synchronous reset, all four control words are zero, the mode field is normal (2'b01), and `busy`, `done` and `err` are low.
- R2: A request fails unless all of the following hold: 1 ≤ NR ≤ 64, 1 ≤ NF ≤ 8192 and 1 ≤ NO ≤ 16; the VCO, 24000·NF/NR kHz, lies within [440000, 2200000]; and the output, VCO/NO, lies within [27500, 2200000]. A failing request pulses `err` for one cycle two cycles after the start cycle, and changes neither the control words nor the mode field.
- R3: A request whose NO is odd and not 1 is rejected as in R2, even when its frequencies are in range.
- R4: For an accepted request, control word 0 holds NR−1 in bits 13:8 and NO−1 in bits 3:0, and control word 1 holds NF−1 in bits 12:0. All other bits of both words are zero.
- R5: Control word 2 holds (NF>>1)−1 in bits 11:0, and its other bits are zero.
- R6: For an accepted request, the mode field becomes slow (2'b00) one cycle after the request is taken. PLL reset (bit 5 of control word 3) rises one cycle after that, and the divider words are written one cycle after reset rises.
- R7: PLL reset stays high for HOLD_CYC+1 cycles, where HOLD_CYC = CLK_MHZ·HOLD_US (1000 by default). It is then cleared.
- R8: When the lock input is sampled high while the block waits for lock, the mode field returns to normal and `done` pulses for one cycle at the same edge.
- R9: If lock is not seen within LOCK_TMO cycles after reset is released, `err` pulses for one cycle and the mode field stays slow.
- R10: A start request that arrives while `busy` is high is ignored, and the operation already in flight completes with its original divider values.
- R11: `busy` is high from the cycle after the start is taken until the cycle in which `done` or `err` pulses, where it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to reprogram the PLL |
| nr_in | input | 7 | Reference divider value (1..64) |
| nf_in | input | 14 | Feedback multiplier value (1..8192) |
| no_in | input | 5 | Output divider value (1..16) |
| lock | input | 1 | PLL lock status |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: PLL locked and back in normal mode |
| err | output | 1 | One-cycle pulse: request rejected or lock timed out |
| pll_mode | output | 2 | PLL mode field: 0 slow, 1 normal |
| pll_con0 | output | 32 | Control word 0: NR−1 and NO−1 fields |
| pll_con1 | output | 32 | Control word 1: NF−1 field |
| pll_con2 | output | 32 | Control word 2: bandwidth-adjust field |
| pll_con3 | output | 32 | Control word 3: PLL reset in bit 5 |

## Verification
The hardest situations to reach from the ports are the exact edges of the legal window, where a single step of NF or NR moves the VCO across 440 MHz or 2200 MHz. They are reached with ratios chosen to land exactly on each bound: NF=55 with NR=3 and NO=16 sits on both lower limits at once, and NF=275 with NR=3 sits on the upper VCO limit. Each of these is paired with a neighbour one step outside the window. The lock timeout is reached by withholding lock for the whole window. A second start is issued in the middle of a hold to show that the request in flight keeps its values. A behavioural model in the bench predicts every output on every clock, and the reset pulse width is counted separately.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int WORD_W  = 32;
    localparam int NR_W    = 6;
    localparam int NF_W    = 13;
    localparam int NO_W    = 4;
    localparam int BW_W    = 12;
    localparam int MODE_W  = 2;

    // field positions decoded by the PLL control neighbour
    localparam int NR_POS  = 8;
    localparam int NO_POS  = 0;
    localparam int NF_POS  = 0;
    localparam int BW_POS  = 0;
    localparam int RST_BIT = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ARM,
        ST_PROG,
        ST_HOLD,
        ST_LOCK
    } seq_state_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_SLOW   = 2'd0,
        MODE_NORMAL = 2'd1
    } pll_mode_e;

    // divider values as requested (not yet minus-one encoded)
    typedef struct packed {
        logic [NR_W:0] nr;
        logic [NF_W:0] nf;
        logic [NO_W:0] no;
    } div_req_t;

    function automatic logic [NR_W-1:0] enc_nr(input logic [NR_W:0] v);
        logic [NR_W:0] t;
        t = v - 1'b1;
        return t[NR_W-1:0];
    endfunction

    function automatic logic [NF_W-1:0] enc_nf(input logic [NF_W:0] v);
        logic [NF_W:0] t;
        t = v - 1'b1;
        return t[NF_W-1:0];
    endfunction

    function automatic logic [NO_W-1:0] enc_no(input logic [NO_W:0] v);
        logic [NO_W:0] t;
        t = v - 1'b1;
        return t[NO_W-1:0];
    endfunction

    function automatic logic [BW_W-1:0] enc_bw(input logic [NF_W:0] v);
        logic [NF_W:0] t;
        t = (v >> 1) - 1'b1;
        return t[BW_W-1:0];
    endfunction

endpackage

// File: rtl/pllseq_range.sv
module pllseq_range
    import pllseq_pkg::*;
#(
    parameter int REF_KHZ     = 24000,
    parameter int VCO_MIN_KHZ = 440000,
    parameter int VCO_MAX_KHZ = 2200000,
    parameter int OUT_MIN_KHZ = 27500,
    parameter int OUT_MAX_KHZ = 2200000
) (
    input  div_req_t req,
    output logic     legal
);

    localparam logic [63:0] NR_MAX = 64'(1) << NR_W;
    localparam logic [63:0] NF_MAX = 64'(1) << NF_W;
    localparam logic [63:0] NO_MAX = 64'(1) << NO_W;

    logic [63:0] nr_w, nf_w, no_w, num, nrno;
    logic        bounds_ok, odd_ok, vco_ok, out_ok;

    // Compare by cross multiplication: exact, and no divider in the path.
    always_comb begin
        nr_w = 64'(req.nr);
        nf_w = 64'(req.nf);
        no_w = 64'(req.no);
        num  = 64'(REF_KHZ) * nf_w;
        nrno = nr_w * no_w;

        bounds_ok = (nr_w != 0) && (nr_w <= NR_MAX) &&
                    (nf_w != 0) && (nf_w <= NF_MAX) &&
                    (no_w != 0) && (no_w <= NO_MAX);
        odd_ok    = (no_w == 64'd1) || (req.no[0] == 1'b0);
        vco_ok    = (num >= 64'(VCO_MIN_KHZ) * nr_w) &&
                    (num <= 64'(VCO_MAX_KHZ) * nr_w);
        out_ok    = (num >= 64'(OUT_MIN_KHZ) * nrno) &&
                    (num <= 64'(OUT_MAX_KHZ) * nrno);
        legal     = bounds_ok && odd_ok && vco_ok && out_ok;
    end

endmodule

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
    import pllseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       legal,
    input  logic       lock,
    input  logic       tmr_zero,
    output seq_state_e state,
    output logic       take_req,
    output logic       set_slow,
    output logic       set_rst,
    output logic       write_div,
    output logic       clr_rst,
    output logic       set_norm,
    output logic       ld_hold,
    output logic       ld_lock,
    output logic       tmr_dec,
    output logic       done,
    output logic       err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                ST_IDLE:  if (start) state <= ST_CHECK;
                ST_CHECK: begin
                    if (legal) begin
                        state <= ST_ARM;
                    end else begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_ARM:   state <= ST_PROG;
                ST_PROG:  state <= ST_HOLD;
                ST_HOLD:  if (tmr_zero) state <= ST_LOCK;
                ST_LOCK: begin
                    if (lock) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (tmr_zero) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        take_req  = (state == ST_IDLE) && start;
        set_slow  = (state == ST_CHECK) && legal;
        set_rst   = (state == ST_ARM);
        write_div = (state == ST_PROG);
        ld_hold   = (state == ST_PROG);
        clr_rst   = (state == ST_HOLD) && tmr_zero;
        ld_lock   = clr_rst;
        set_norm  = (state == ST_LOCK) && lock;
        tmr_dec   = ((state == ST_HOLD) || (state == ST_LOCK)) && !tmr_zero;
    end

    // R8, R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R8
    done_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(lock));

endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
    import pllseq_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int HOLD_US  = 10,
    parameter int LOCK_TMO = 2000,
    parameter int REF_KHZ  = 24000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [NR_W:0]     nr_in,
    input  logic [NF_W:0]     nf_in,
    input  logic [NO_W:0]     no_in,
    input  logic              lock,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [MODE_W-1:0] pll_mode,
    output logic [WORD_W-1:0] pll_con0,
    output logic [WORD_W-1:0] pll_con1,
    output logic [WORD_W-1:0] pll_con2,
    output logic [WORD_W-1:0] pll_con3
);

    localparam int HOLD_CYC = CLK_MHZ * HOLD_US;
    localparam int TMR_MAX  = (HOLD_CYC > LOCK_TMO) ? HOLD_CYC : LOCK_TMO;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);

    div_req_t   req_q;
    seq_state_e state;
    pll_mode_e  mode_q;
    logic       legal;
    logic       take_req, set_slow, set_rst, write_div, clr_rst, set_norm;
    logic       ld_hold, ld_lock, tmr_dec, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic [WORD_W-1:0] w0_next, w1_next, w2_next;

    pllseq_range #(.REF_KHZ(REF_KHZ)) i_range (
        .req   (req_q),
        .legal (legal)
    );

    pllseq_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .legal     (legal),
        .lock      (lock),
        .tmr_zero  (tmr_zero),
        .state     (state),
        .take_req  (take_req),
        .set_slow  (set_slow),
        .set_rst   (set_rst),
        .write_div (write_div),
        .clr_rst   (clr_rst),
        .set_norm  (set_norm),
        .ld_hold   (ld_hold),
        .ld_lock   (ld_lock),
        .tmr_dec   (tmr_dec),
        .done      (done),
        .err       (err)
    );

    assign tmr_val = ld_hold ? TMR_W'(HOLD_CYC - 1) : TMR_W'(LOCK_TMO - 1);

    pllseq_timer #(.W(TMR_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_hold || ld_lock),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    always_comb begin
        w0_next = '0;
        w1_next = '0;
        w2_next = '0;
        w0_next[NR_POS +: NR_W] = enc_nr(req_q.nr);
        w0_next[NO_POS +: NO_W] = enc_no(req_q.no);
        w1_next[NF_POS +: NF_W] = enc_nf(req_q.nf);
        w2_next[BW_POS +: BW_W] = enc_bw(req_q.nf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= '0;
            mode_q   <= MODE_NORMAL;
            pll_con0 <= '0;
            pll_con1 <= '0;
            pll_con2 <= '0;
            pll_con3 <= '0;
        end else begin
            if (take_req) req_q <= '{nr: nr_in, nf: nf_in, no: no_in};
            if (set_slow) mode_q <= MODE_SLOW;
            if (set_rst)  pll_con3[RST_BIT] <= 1'b1;
            if (clr_rst)  pll_con3[RST_BIT] <= 1'b0;
            if (write_div) begin
                pll_con0 <= w0_next;
                pll_con1 <= w1_next;
                pll_con2 <= w2_next;
            end
            if (set_norm) mode_q <= MODE_NORMAL;
        end
    end

    assign pll_mode = mode_q;
    assign busy     = (state != ST_IDLE);

    // R6
    rst_only_slow_chk: assert property (@(posedge clk) disable iff (rst)
        pll_con3[RST_BIT] |-> (pll_mode == MODE_SLOW));

    // R6
    div_write_in_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pll_con0) || !$stable(pll_con1) || !$stable(pll_con2))
            |-> pll_con3[RST_BIT]);

    // R8
    normal_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (pll_mode == MODE_NORMAL && $past(pll_mode) == MODE_SLOW) |-> $past(lock));

    // R10
    req_held_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(req_q));

    // R11
    busy_low_on_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> !busy);

endmodule

// File: tb/test_pll_prog_seq.sv
module test_pll_prog_seq;

    localparam int HOLD = 1000;
    localparam int TMO  = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  nr_in = '0;
    logic [13:0] nf_in = '0;
    logic [4:0]  no_in = '0;
    logic        lock = 1'b0;
    logic        busy, done, err;
    logic [1:0]  pll_mode;
    logic [31:0] pll_con0, pll_con1, pll_con2, pll_con3;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pll_prog_seq i_pll_prog_seq (
        .clk(clk), .rst(rst), .start(start),
        .nr_in(nr_in), .nf_in(nf_in), .no_in(no_in), .lock(lock),
        .busy(busy), .done(done), .err(err), .pll_mode(pll_mode),
        .pll_con0(pll_con0), .pll_con1(pll_con1),
        .pll_con2(pll_con2), .pll_con3(pll_con3)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit legal_req(input int nr, input int nf, input int no);
        longint v;
        v = 64'd24000 * longint'(nf);
        if (nr < 1 || nr > 64 || nf < 1 || nf > 8192 || no < 1 || no > 16) return 0;
        if (no != 1 && (no % 2) != 0) return 0;
        if (v < 64'd440000 * nr || v > 64'd2200000 * nr) return 0;
        if (v < 64'd27500 * nr * no || v > 64'd2200000 * nr * no) return 0;
        return 1;
    endfunction

    // behavioural reference model, updated at each rising edge
    int          m_stage = 0;
    int          m_cnt = 0;
    int          l_nr = 0, l_nf = 0, l_no = 0;
    longint      e_c0 = 0, e_c1 = 0, e_c2 = 0, e_c3 = 0;
    int          e_mode = 1;
    bit          e_done = 0, e_err = 0, e_busy = 0;

    always @(posedge clk) begin
        e_done = 0;
        e_err  = 0;
        if (rst) begin
            m_stage = 0; m_cnt = 0;
            e_c0 = 0; e_c1 = 0; e_c2 = 0; e_c3 = 0; e_mode = 1;
        end else begin
            case (m_stage)
                0: if (start) begin
                    l_nr = nr_in; l_nf = nf_in; l_no = no_in; m_stage = 1;
                end
                1: if (!legal_req(l_nr, l_nf, l_no)) begin
                    e_err = 1; m_stage = 0;
                end else begin
                    e_mode = 0; m_stage = 2;
                end
                2: begin e_c3 = 32; m_stage = 3; end
                3: begin
                    e_c0 = ((l_nr - 1) << 8) | (l_no - 1);
                    e_c1 = l_nf - 1;
                    e_c2 = ((l_nf >> 1) - 1) & 'hFFF;
                    m_cnt = 0; m_stage = 4;
                end
                4: begin
                    m_cnt++;
                    if (m_cnt == HOLD) begin e_c3 = 0; m_cnt = 0; m_stage = 5; end
                end
                default: begin
                    m_cnt++;
                    if (lock) begin e_mode = 1; e_done = 1; m_stage = 0; end
                    else if (m_cnt == TMO) begin e_err = 1; m_stage = 0; end
                end
            endcase
        end
        e_busy = (m_stage != 0);
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            chk("R4", "con0", pll_con0, e_c0);
            chk("R4", "con1", pll_con1, e_c1);
            chk("R5", "con2", pll_con2, e_c2);
            chk("R7", "con3", pll_con3, e_c3);
            chk("R6", "mode", pll_mode, e_mode);
            chk("R11", "busy", busy, e_busy);
            chk("R8", "done", done, e_done);
            chk("R2", "err", err, e_err);
        end
    end

    // lock stand-in driven from the port image
    bit lock_en = 0;
    int lock_dly = 0;
    bit armed = 0;
    int rel_cnt = 0;
    int rst_w = 0;
    always @(negedge clk) begin
        if (pll_con3[5]) begin armed = 1; rel_cnt = 0; rst_w++; end
        else if (!busy) begin armed = 0; rel_cnt = 0; end
        else rel_cnt++;
        lock = lock_en && armed && !pll_con3[5] && (rel_cnt >= lock_dly);
    end

    task automatic run_req(input int nr, input int nf, input int no,
                           input bit en, input int dly, input bit interrupt,
                           output bit got_done, output bit got_err);
        @(negedge clk);
        nr_in = 7'(nr); nf_in = 14'(nf); no_in = 5'(no);
        lock_en = en; lock_dly = dly; rst_w = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_done = 0; got_err = 0;
        for (int i = 0; i < 5000; i++) begin
            if (interrupt && i == 50) begin
                nr_in = 7'd2; nf_in = 14'd100; no_in = 5'd2; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (done || err) begin
                got_done = done; got_err = err;
                break;
            end
        end
        start = 1'b0;
        lock_en = 0;
    endtask

    initial begin
        #2000000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        bit d, e;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "con0 reset", pll_con0, 0);
        chk("R1", "con3 reset", pll_con3, 0);
        chk("R1", "mode reset", pll_mode, 1);
        chk("R1", "flags reset", {busy, done, err}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // accepted, 1800 MHz, second start mid-hold (R10)
        run_req(1, 75, 1, 1, 3, 1, d, e);
        chk("R8", "done seen", d, 1);
        chk("R10", "con0 keeps first", pll_con0, 32'h0000_0000);
        chk("R10", "con1 keeps first", pll_con1, 74);
        chk("R7", "reset width", rst_w, HOLD + 1);

        // VCO too low
        run_req(1, 10, 1, 1, 0, 0, d, e);
        chk("R2", "low vco err", e, 1);
        chk("R2", "con1 untouched", pll_con1, 74);
        chk("R2", "mode untouched", pll_mode, 1);

        // odd output divider
        run_req(1, 75, 3, 1, 0, 0, d, e);
        chk("R3", "odd no err", e, 1);
        chk("R3", "con0 untouched", pll_con0, 0);

        // even divider accepted
        run_req(2, 100, 2, 1, 0, 0, d, e);
        chk("R4", "nr2 no2 done", d, 1);
        chk("R4", "con0 fields", pll_con0, 32'h0000_0101);
        chk("R5", "bw field", pll_con2, 49);

        // both lower limits exactly
        run_req(3, 55, 16, 1, 5, 0, d, e);
        chk("R2", "lower edge accepted", d, 1);
        chk("R4", "con0 edge", pll_con0, 32'h0000_020F);
        // one step below
        run_req(3, 54, 16, 1, 0, 0, d, e);
        chk("R2", "below lower edge rejected", e, 1);
        // upper VCO edge, and one step above
        run_req(3, 275, 1, 1, 1, 0, d, e);
        chk("R2", "upper edge accepted", d, 1);
        run_req(1, 92, 1, 1, 0, 0, d, e);
        chk("R2", "above upper edge rejected", e, 1);
        // NF outside field
        run_req(64, 8193, 16, 1, 0, 0, d, e);
        chk("R2", "nf range rejected", e, 1);

        // lock never comes
        run_req(1, 50, 2, 0, 0, 0, d, e);
        chk("R9", "timeout err", e, 1);
        chk("R9", "mode stays slow", pll_mode, 0);
        chk("R9", "reset released", pll_con3, 0);

        // recovery after timeout
        run_req(1, 50, 2, 1, 2, 0, d, e);
        chk("R8", "recovered done", d, 1);
        chk("R8", "mode normal", pll_mode, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule